// File: doc/BRIEF.md
# Ordered Task Doorbell Queue

This block holds the start requests of a command-queue engine that serves up to 32 tasks. Software rings tasks by writing a 32-bit mask to a doorbell register. The block breaks the mask into task numbers and loads them into an ordered queue. A downstream dispatcher takes task numbers from the head of that queue through a valid/ready handshake. The block does not acknowledge the register write until every newly requested task from that write is in the queue. It loads one task per cycle, so a write that rings many tasks stalls the bus for several cycles.

The block also holds two other registers. The first gathers completion flags, which software clears by writing 1s. The second runs one task clear at a time. A cleared task that is still queued is not removed from the queue storage. Its doorbell bit drops, and the dispatcher never sees the entry: the head logic discards it when it reaches the front. A task that has already been handed to the dispatcher is cleared only when the dispatcher confirms with an acknowledge pulse. Dropping the engine enable empties the queue and resets the doorbell and clear state within one cycle.

The register port uses a select field: 0 is the doorbell, 1 is the completion register (write 1 to clear), 2 is task clear, and 3 is an unused write that is acknowledged at once. Every task state is visible on the readback outputs.

Top module: `cq_doorbell_queue`

## Requirements
- R1: After reset, the doorbell, completion and clear outputs are all zero and `disp_valid` is low.
- R2: Within one doorbell write, the newly requested tasks reach the dispatcher in ascending task-number order.
- R3: All tasks from an earlier doorbell write are dispatched before any task from a later write.
- R4: A doorbell write that requests k new tasks (k ≥ 1) has `wr_ready` high in its k-th cycle of `wr_valid`. A write with no new task is ready in its first cycle.
- R5: Doorbell bits written 0 have no effect. Bits of tasks whose doorbell bit is already 1 are not queued again. The doorbell output becomes the OR of the previous value and the written mask.
- R6: A doorbell bit stays 1 after dispatch until a completion pulse for that task. That pulse clears the bit and sets the matching completion bit. A completion pulse for a task whose doorbell bit is 0 changes nothing. Writing 1 to a completion bit (select 1) clears it.
- R7: A task-clear write (select 2) sets only the lowest set bit of the written data. If that task has not been handed to the dispatcher, its doorbell bit and the clear bit both drop one cycle later. Its queued entry is then never presented.
- R8: A clear of a task already handed to the dispatcher keeps its clear and doorbell bits at 1 until a `clr_ack` pulse. Both bits drop in the cycle after that pulse.
- R9: While a clear bit is 1, a further task-clear write is ignored. A task-clear write of all zeros is ignored.
- R10: With `engine_en` low, one clock zeroes the doorbell and clear bits and empties the queue. Doorbell writes made while the engine is disabled are acknowledged in one cycle and change nothing.
- R11: While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and `disp_task` stays unchanged. This holds while no clear, completion or disable is in progress.
- R12: A doorbell write that re-rings a cleared task whose old entry is still queued stalls. It proceeds only once that entry has been discarded at the head, and the task is then queued behind the entries ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| engine_en | input | 1 | Engine enable; low flushes all task state |
| wr_valid | input | 1 | Register write request, held until `wr_ready` |
| wr_sel | input | 2 | Register select: 0 doorbell, 1 completion, 2 task clear, 3 none |
| wr_data | input | 32 | Write data, one bit per task |
| wr_ready | output | 1 | Write accepted in this cycle |
| disp_valid | output | 1 | Head task is available to the dispatcher |
| disp_task | output | 5 | Head task number |
| disp_ready | input | 1 | Dispatcher takes the head task |
| cmpl_valid | input | 1 | Task completion pulse |
| cmpl_task | input | 5 | Number of the completed task |
| clr_ack | input | 1 | Dispatcher confirms the clear of a dispatched task |
| db_bits | output | 32 | Doorbell register value |
| done_bits | output | 32 | Completion register value |
| clr_bits | output | 32 | Task-clear register value |

## Verification
A corrupted queue pointer or a lost in-queue flag shows up at the ports as a dispatch out of the ordered sequence, or as a dispatch of a cleared task. The first such dispatch exposes it, so the bench compares every dispatched number against a model built from the written masks. A wrong expander mask changes the number of stall cycles of the write that caused it, which the bench counts for every write. Clear-state faults show within one or two cycles as a clear bit that stays set, drops too early, or leaves the doorbell bit standing.

// File: rtl/cqdq_pkg.sv
package cqdq_pkg;

  typedef enum logic [1:0] {
    SEL_DOORBELL = 2'd0,
    SEL_DONE     = 2'd1,
    SEL_CLEAR    = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  typedef enum logic {
    EXP_IDLE = 1'b0,
    EXP_BUSY = 1'b1
  } exp_state_e;

endpackage

// File: rtl/cqdq_expander.sv
// Turns a doorbell mask into one task number per cycle, lowest first.
module cqdq_expander
  import cqdq_pkg::*;
#(
  parameter int unsigned NT = 32,
  localparam int unsigned TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          start,
  input  logic          hold,
  input  logic [NT-1:0] req_bits,
  output logic          push_en,
  output logic [TW-1:0] push_task,
  output logic          done
);

  exp_state_e    state_q, state_d;
  logic [NT-1:0] mask_q, mask_d;
  logic          mask_en;
  logic [NT-1:0] eff;
  logic [NT-1:0] rest;
  logic [TW-1:0] low_idx;
  logic          busy;

  assign busy = (state_q == EXP_BUSY);

  always_comb begin
    if (busy) begin
      eff = mask_q;
    end else if (start && !hold) begin
      eff = req_bits;
    end else begin
      eff = '0;
    end
  end

  always_comb begin
    low_idx = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (eff[i]) low_idx = TW'(i);
    end
  end

  assign rest      = eff & (eff - NT'(1));
  assign push_en   = (eff != '0) && !flush;
  assign push_task = low_idx;

  always_comb begin
    if (busy) begin
      done = (rest == '0) || flush;
    end else begin
      done = start && !hold && (rest == '0);
    end
  end

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (flush) begin
      state_d = EXP_IDLE;
      mask_d  = '0;
      mask_en = 1'b1;
    end else if (busy || (start && !hold)) begin
      mask_en = 1'b1;
      mask_d  = rest;
      state_d = (rest != '0) ? EXP_BUSY : EXP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EXP_IDLE;
      mask_q  <= '0;
    end else if (mask_en) begin
      state_q <= state_d;
      mask_q  <= mask_d;
    end
  end

  assert_busy_has_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mask_q != '0));

endmodule

// File: rtl/cqdq_fifo.sv
// Ordered task queue; head is read combinationally.
module cqdq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 5,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= '0;
        end else if (do_push && (wr_ptr_q == PW'(g))) begin
          mem_q[g] <= push_data;
        end
      end
    end
  endgenerate

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || flush));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (cnt_q <= CW'(1)));

endmodule

// File: rtl/cqdq_task_state.sv
// Per-task doorbell, in-queue, completion and clear state.
module cqdq_task_state #(
  parameter int unsigned NT = 32,
  localparam int unsigned TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          engine_en,
  input  logic          push_en,
  input  logic [TW-1:0] push_task,
  input  logic          pop_en,
  input  logic [TW-1:0] pop_task,
  input  logic          cmpl_valid,
  input  logic [TW-1:0] cmpl_task,
  input  logic          done_wr_en,
  input  logic [NT-1:0] done_wr_bits,
  input  logic          clr_wr_en,
  input  logic [NT-1:0] clr_wr_bits,
  input  logic          clr_ack,
  output logic [NT-1:0] db_q,
  output logic [NT-1:0] inq_q,
  output logic [NT-1:0] done_q,
  output logic [NT-1:0] clr_q
);

  logic [NT-1:0] db_d, inq_d, done_d, clr_d;
  logic [TW-1:0] clr_task;
  logic          clr_dispatched;
  logic          clr_fire;
  logic [NT-1:0] clr_pick;
  logic          cmpl_live;

  always_comb begin
    clr_task = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (clr_q[i]) clr_task = TW'(i);
    end
  end

  always_comb begin
    clr_pick = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (clr_wr_bits[i]) clr_pick = NT'(1) << i;
    end
  end

  assign clr_dispatched = db_q[clr_task] && !inq_q[clr_task];
  assign clr_fire       = (clr_q != '0) && (!clr_dispatched || clr_ack);
  assign cmpl_live      = cmpl_valid && db_q[cmpl_task];

  always_comb begin
    db_d  = db_q;
    inq_d = inq_q;
    clr_d = clr_q;
    if (!engine_en) begin
      db_d  = '0;
      inq_d = '0;
      clr_d = '0;
    end else begin
      if (push_en) begin
        db_d[push_task]  = 1'b1;
        inq_d[push_task] = 1'b1;
      end
      if (pop_en)    inq_d[pop_task] = 1'b0;
      if (cmpl_live) db_d[cmpl_task] = 1'b0;
      if (clr_fire) begin
        db_d[clr_task] = 1'b0;
        clr_d          = '0;
      end else if (clr_wr_en && (clr_q == '0)) begin
        clr_d = clr_pick;
      end
    end
  end

  always_comb begin
    done_d = done_q;
    if (done_wr_en) done_d = done_d & ~done_wr_bits;
    if (cmpl_live)  done_d[cmpl_task] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q   <= '0;
      inq_q  <= '0;
      done_q <= '0;
      clr_q  <= '0;
    end else begin
      db_q   <= db_d;
      inq_q  <= inq_d;
      done_q <= done_d;
      clr_q  <= clr_d;
    end
  end

  assert_single_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_q));

  assert_no_requeue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (!db_q[push_task] && !inq_q[push_task]));

  assert_disable_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_en |=> (db_q == '0) && (inq_q == '0) && (clr_q == '0));

  assert_clear_waits_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_q != '0) && clr_dispatched && !clr_ack && engine_en) |=> (clr_q == $past(clr_q)));

endmodule

// File: rtl/cq_doorbell_queue.sv
module cq_doorbell_queue
  import cqdq_pkg::*;
#(
  parameter int unsigned NT = 32,
  localparam int unsigned TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          engine_en,
  input  logic          wr_valid,
  input  logic [1:0]    wr_sel,
  input  logic [NT-1:0] wr_data,
  output logic          wr_ready,
  output logic          disp_valid,
  output logic [TW-1:0] disp_task,
  input  logic          disp_ready,
  input  logic          cmpl_valid,
  input  logic [TW-1:0] cmpl_task,
  input  logic          clr_ack,
  output logic [NT-1:0] db_bits,
  output logic [NT-1:0] done_bits,
  output logic [NT-1:0] clr_bits
);

  reg_sel_e      sel;
  logic [NT-1:0] db_q, inq_q, done_q, clr_q;
  logic          exp_start, exp_hold, exp_done;
  logic [NT-1:0] exp_req;
  logic          push_en;
  logic [TW-1:0] push_task;
  logic [TW-1:0] head;
  logic          q_empty, q_full;
  logic          head_live;
  logic          pop_en;

  assign sel = reg_sel_e'(wr_sel);

  // Doorbell expansion: only tasks neither rung nor still queued.
  assign exp_start = wr_valid && (sel == SEL_DOORBELL);
  assign exp_hold  = engine_en && ((wr_data & inq_q & ~db_q) != '0);
  assign exp_req   = engine_en ? (wr_data & ~db_q & ~inq_q) : '0;

  cqdq_expander #(.NT(NT)) u_expander (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!engine_en),
    .start     (exp_start),
    .hold      (exp_hold),
    .req_bits  (exp_req),
    .push_en   (push_en),
    .push_task (push_task),
    .done      (exp_done)
  );

  cqdq_fifo #(.DEPTH(NT), .W(TW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!engine_en),
    .push      (push_en),
    .push_data (push_task),
    .pop       (pop_en),
    .head      (head),
    .empty     (q_empty),
    .full      (q_full)
  );

  // Head entries of cleared tasks are dropped without a handshake.
  assign head_live  = db_q[head];
  assign disp_valid = engine_en && !q_empty && head_live;
  assign disp_task  = head;
  assign pop_en     = engine_en && !q_empty && (!head_live || disp_ready);

  cqdq_task_state #(.NT(NT)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .engine_en    (engine_en),
    .push_en      (push_en),
    .push_task    (push_task),
    .pop_en       (pop_en),
    .pop_task     (head),
    .cmpl_valid   (cmpl_valid),
    .cmpl_task    (cmpl_task),
    .done_wr_en   (wr_valid && (sel == SEL_DONE)),
    .done_wr_bits (wr_data),
    .clr_wr_en    (wr_valid && (sel == SEL_CLEAR)),
    .clr_wr_bits  (wr_data),
    .clr_ack      (clr_ack),
    .db_q         (db_q),
    .inq_q        (inq_q),
    .done_q       (done_q),
    .clr_q        (clr_q)
  );

  assign wr_ready  = (sel == SEL_DOORBELL) ? exp_done : 1'b1;
  assign db_bits   = db_q;
  assign done_bits = done_q;
  assign clr_bits  = clr_q;

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(disp_valid && !disp_ready && (clr_q == '0) && !cmpl_valid && engine_en) && engine_en)
      |-> (disp_valid && $stable(disp_task)));

  assert_queue_not_full_on_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_en);

endmodule

// File: tb/cq_doorbell_queue_bench.sv
module cq_doorbell_queue_bench;

  logic        clk;
  logic        rst_n;
  logic        engine_en;
  logic        wr_valid;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        wr_ready;
  logic        disp_valid;
  logic [4:0]  disp_task;
  logic        disp_ready;
  logic        cmpl_valid;
  logic [4:0]  cmpl_task;
  logic        clr_ack;
  logic [31:0] db_bits, done_bits, clr_bits;

  int n_chk  = 0;
  int n_fail = 0;

  cq_doorbell_queue u_cq_doorbell_queue (
    .clk(clk), .rst_n(rst_n), .engine_en(engine_en),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data), .wr_ready(wr_ready),
    .disp_valid(disp_valid), .disp_task(disp_task), .disp_ready(disp_ready),
    .cmpl_valid(cmpl_valid), .cmpl_task(cmpl_task), .clr_ack(clr_ack),
    .db_bits(db_bits), .done_bits(done_bits), .clr_bits(clr_bits)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Stimulus table: doorbell mask, expected write cycles
  localparam int NROW = 5;
  localparam logic [31:0] TBL_MASK [NROW] = '{32'h0000_0081, 32'h0000_0005,
                                             32'h8000_0010, 32'h0000_0000,
                                             32'h0000_0F00};
  localparam int TBL_CYC [NROW] = '{2, 1, 2, 1, 4};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data,
                           output int cyc);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = sel;
    wr_data  = data;
    cyc      = 1;
    #1;
    while (!wr_ready && cyc < 200) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic take(output int tnum);
    int guard;
    guard = 0;
    @(negedge clk);
    #1;
    while (!disp_valid && guard < 100) begin
      @(negedge clk);
      #1;
      guard++;
    end
    tnum = disp_valid ? int'(disp_task) : -1;
    disp_ready = 1'b1;
    @(posedge clk);
    #1;
    disp_ready = 1'b0;
  endtask

  task automatic complete(input int t);
    @(negedge clk);
    cmpl_valid = 1'b1;
    cmpl_task  = 5'(t);
    @(posedge clk);
    #1;
    cmpl_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int got;
    int exp_order [64];
    int exp_n;
    logic [31:0] model_db;

    rst_n = 1'b0; engine_en = 1'b1; wr_valid = 1'b0; wr_sel = 2'd3; wr_data = '0;
    disp_ready = 1'b0; cmpl_valid = 1'b0; cmpl_task = '0; clr_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(db_bits == 0, "R1 doorbell", db_bits, 0);
    chk(done_bits == 0, "R1 done", done_bits, 0);
    chk(clr_bits == 0, "R1 clear", clr_bits, 0);
    chk(!disp_valid, "R1 disp_valid", 32'(disp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2, R3, R4, R5
    exp_n = 0;
    model_db = '0;
    for (int r = 0; r < NROW; r++) begin
      for (int b = 0; b < 32; b++) begin
        if (TBL_MASK[r][b] && !model_db[b]) begin
          exp_order[exp_n] = b;
          exp_n++;
        end
      end
      model_db = model_db | TBL_MASK[r];
      reg_write(2'd0, TBL_MASK[r], cyc);
      chk(cyc == TBL_CYC[r], "R4 write stall cycles", 32'(cyc), 32'(TBL_CYC[r]));
      chk(db_bits == model_db, "R5 doorbell accumulates", db_bits, model_db);
    end

    // R11: head held while dispatcher stalls
    @(negedge clk);
    #1;
    chk(disp_valid && disp_task == 5'd0, "R11 head present", 32'(disp_task), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(disp_valid && disp_task == 5'd0, "R11 head stable", 32'(disp_task), 0);

    // R2/R3: dispatch order against model
    for (int k = 0; k < exp_n; k++) begin
      take(got);
      chk(got == exp_order[k], "R2 R3 dispatch order", 32'(got), 32'(exp_order[k]));
    end
    @(negedge clk);
    #1;
    chk(!disp_valid, "R5 no requeue after drain", 32'(disp_valid), 0);
    chk(db_bits == 32'h8000_0F95, "R6 bits kept after dispatch", db_bits, 32'h8000_0F95);

    // R6: completion and W1C
    complete(7);
    chk(db_bits == 32'h8000_0F15, "R6 completion clears doorbell", db_bits, 32'h8000_0F15);
    chk(done_bits == 32'h0000_0080, "R6 completion sets done", done_bits, 32'h80);
    complete(5);
    chk(done_bits == 32'h0000_0080, "R6 idle completion ignored", done_bits, 32'h80);
    reg_write(2'd1, 32'h0000_0080, cyc);
    chk(done_bits == 0, "R6 done write-1-clear", done_bits, 0);

    // R7: clear of a queued task
    reg_write(2'd0, 32'h0000_7000, cyc);
    chk(cyc == 3, "R4 three-task write", 32'(cyc), 3);
    reg_write(2'd2, 32'h0000_2000, cyc);
    chk(clr_bits == 32'h0000_2000, "R7 clear bit set", clr_bits, 32'h2000);
    @(posedge clk);
    #1;
    chk(clr_bits == 0, "R7 clear self-clears", clr_bits, 0);
    chk(db_bits[13] == 1'b0, "R7 doorbell dropped", db_bits, 32'h8000_5F15);
    take(got);
    chk(got == 12, "R7 first survivor", 32'(got), 12);
    take(got);
    chk(got == 14, "R7 cleared entry skipped", 32'(got), 14);

    // R8/R9: clear of a dispatched task, lowest bit taken
    reg_write(2'd2, 32'h0000_0030, cyc);
    chk(clr_bits == 32'h0000_0010, "R7 lowest bit picked", clr_bits, 32'h10);
    repeat (3) @(posedge clk);
    #1;
    chk(clr_bits == 32'h0000_0010, "R8 clear waits for ack", clr_bits, 32'h10);
    chk(db_bits[4] == 1'b1, "R8 doorbell kept", db_bits, 32'h8000_5F15);
    reg_write(2'd2, 32'h0000_0100, cyc);
    chk(clr_bits == 32'h0000_0010, "R9 second clear ignored", clr_bits, 32'h10);
    @(negedge clk);
    clr_ack = 1'b1;
    @(posedge clk);
    #1;
    clr_ack = 1'b0;
    chk(clr_bits == 0, "R8 clear ends on ack", clr_bits, 0);
    chk(db_bits == 32'h8000_5F05, "R8 doorbell dropped on ack", db_bits, 32'h8000_5F05);
    reg_write(2'd2, 32'h0000_0000, cyc);
    chk(clr_bits == 0, "R9 zero clear ignored", clr_bits, 0);

    // R10: disable flushes queue and doorbell
    reg_write(2'd0, 32'h0000_00F0, cyc);
    chk(cyc == 4, "R4 four-task write", 32'(cyc), 4);
    @(negedge clk);
    engine_en = 1'b0;
    @(posedge clk);
    #1;
    chk(db_bits == 0, "R10 doorbell zeroed", db_bits, 0);
    reg_write(2'd0, 32'h0000_000F, cyc);
    chk(cyc == 1 && db_bits == 0, "R10 disabled write dropped", db_bits, 0);
    @(negedge clk);
    engine_en = 1'b1;
    @(negedge clk);
    #1;
    chk(!disp_valid, "R10 queue flushed", 32'(disp_valid), 0);

    // R12: re-ring of a cleared task with a stale entry
    reg_write(2'd0, 32'h0000_0007, cyc);
    reg_write(2'd2, 32'h0000_0004, cyc);
    @(posedge clk);
    #1;
    chk(db_bits == 32'h0000_0003, "R7 queued clear", db_bits, 32'h3);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = 2'd0;
    wr_data  = 32'h0000_0004;
    #1;
    chk(!wr_ready, "R12 re-ring stalls", 32'(wr_ready), 0);
    repeat (2) @(negedge clk);
    #1;
    chk(!wr_ready && db_bits == 32'h3, "R12 still stalled", db_bits, 32'h3);
    take(got);
    chk(got == 0, "R12 order before stale", 32'(got), 0);
    take(got);
    chk(got == 1, "R12 order before stale", 32'(got), 1);
    cyc = 0;
    @(negedge clk);
    #1;
    while (!wr_ready && cyc < 50) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    chk(wr_ready, "R12 write resumes", 32'(wr_ready), 1);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    take(got);
    chk(got == 2, "R12 re-rung task dispatched", 32'(got), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule